// File: doc/BRIEF.md
# Automatic Gain Limiter Stepper

This block keeps the gain setting of an audio amplifier channel and pulls that gain down in discrete steps whenever the output peak would go past a programmed limit, so the waveform is never clipped. A two-bit select picks one of four base gains. Each incoming sample carries a peak magnitude. The block compares that magnitude with a limit derived from a threshold code, and moves a gain-step index between 1 (no reduction) and 32 (deepest reduction).

The index climbs by one step per attack holdoff window while overshoots keep arriving. It falls back by one step after a full release window with no overshoot. The block also reports the resulting gain in units of 0.05 dB, which a downstream scaler uses to weight samples. A bypass input turns limiting off and holds the index at its first step. Changing the base-gain select restarts limiting from the first step.

Top module: `agc_gain_limiter`

## Requirements
- R1: After reset the step index is 1 and the reported gain is 403 (20.15 dB in 0.05 dB units) for select code 0.
- R2: At step 1 the gain is the base gain plus 3 units. The select code maps to the base as follows: 0 gives 400 units (20 dB), 1 gives 520 (26 dB), 2 gives 640 (32 dB) and 3 gives 720 (36 dB). The reported gain follows a select change one clock later.
- R3: Each step from 2 to 25 lowers the gain by 10 units. Each step from 26 to 31 lowers it by 20 units. Step 32 lowers it by a further 40 units, so step 32 equals the base minus 397 units.
- R4: The peak limit is floor(min(code, 125) * 179 / 32), which is about 5.6 times the code, with code 125 as the knee. An overshoot is a valid sample whose peak is strictly greater than the limit.
- R5: On an overshoot while the attack holdoff is idle, the index rises by one at that clock edge and the holdoff is loaded with ATK_HOLD (default 3). Overshoots that arrive while the holdoff is counting down do not raise the index.
- R6: The index never goes above 32 or below 1.
- R7: After REL_CYC (default 16) consecutive clocks without an overshoot, the index drops by one and the release count starts again. The index does not drop below 1.
- R8: While bypass is high, the index is 1 from the next clock on, the timers are cleared, and overshoots have no effect.
- R9: A select value that differs from the registered one sets the index to 1 and clears both timers. This takes priority over an overshoot in the same cycle.
- R10: An overshoot in the cycle in which the release count would expire prevents the decrement and restarts the release count.
- R11: A sample with the valid flag low counts as no overshoot, whatever its peak value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gain_sel_i | input | 2 | Base gain select code |
| limit_code_i | input | LCW (8) | Threshold code that sets the peak limit |
| peak_valid_i | input | 1 | Marks a sample peak as present this cycle |
| peak_mag_i | input | PW (12) | Output peak magnitude of the current sample |
| bypass_i | input | 1 | Disables limiting and holds step 1 |
| step_o | output | 6 | Gain-step index, 1 to 32 |
| gain_o | output | GW (10) | Resulting gain in 0.05 dB units |

## Verification
Two functions can fall in the same cycle and contend for the index. The first pair is an overshoot that arrives exactly when the release count expires. The second pair is an overshoot that arrives in the same cycle as a change of the gain select. The bench provokes the select case on purpose by switching the select while the peak stays above the limit. It provokes the release case by driving long random stretches in which sparse overshoots land at every phase of the release count. A behavioural model applies the stated priority order (bypass, then select change, then overshoot, then release), and its index and gain are compared with the design after every clock.

// File: rtl/agc_lim_pkg.sv
package agc_lim_pkg;

    localparam int STEP_W = 6;
    localparam logic [STEP_W-1:0] STEP_MIN   = 6'd1;
    localparam logic [STEP_W-1:0] STEP_MAX   = 6'd32;
    localparam logic [STEP_W-1:0] FINE_END   = 6'd25;
    localparam logic [STEP_W-1:0] COARSE_END = 6'd31;

    localparam int FINE_CDB   = 10;
    localparam int COARSE_CDB = 20;
    localparam int LAST_CDB   = 40;
    localparam int TRIM_CDB   = 3;

    typedef enum logic [1:0] {
        GSEL_20DB = 2'd0,
        GSEL_26DB = 2'd1,
        GSEL_32DB = 2'd2,
        GSEL_36DB = 2'd3
    } gsel_e;

    function automatic int base_cdb(input gsel_e sel);
        case (sel)
            GSEL_20DB: return 400;
            GSEL_26DB: return 520;
            GSEL_32DB: return 640;
            default:   return 720;
        endcase
    endfunction

endpackage

// File: rtl/agc_limit_calc.sv
module agc_limit_calc #(
    parameter int LCW   = 8,
    parameter int PW    = 12,
    parameter int KNEE  = 125,
    parameter int MUL   = 179,
    parameter int SHIFT = 5
) (
    input  logic [LCW-1:0] limit_code_i,
    input  logic           peak_valid_i,
    input  logic [PW-1:0]  peak_mag_i,
    output logic           over_o
);
    localparam int MULW = $clog2(MUL + 1);
    localparam int PRW  = LCW + MULW;

    logic [LCW-1:0] eff_code;
    logic [PRW-1:0] product;
    logic [PRW-1:0] scaled;
    logic [PRW-1:0] peak_ext;

    always_comb begin
        eff_code = (limit_code_i > LCW'(KNEE)) ? LCW'(KNEE) : limit_code_i;
        product  = PRW'(eff_code) * PRW'(MUL);
        scaled   = product >> SHIFT;
        peak_ext = PRW'(peak_mag_i);
        // R4 / R11: strict compare, only for a valid sample
        over_o   = peak_valid_i && (peak_ext > scaled);
    end

endmodule

// File: rtl/agc_gain_map.sv
module agc_gain_map
    import agc_lim_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic [1:0]        sel_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [GW-1:0]     gain_o
);
    logic [STEP_W-1:0] fine_n;
    logic [STEP_W-1:0] coarse_n;
    logic [GW-1:0]     offset;
    logic [GW-1:0]     base;

    always_comb begin
        fine_n   = ((step_i > FINE_END) ? FINE_END : step_i) - STEP_MIN;
        coarse_n = (step_i > FINE_END)
                 ? (((step_i > COARSE_END) ? COARSE_END : step_i) - FINE_END)
                 : '0;
        offset   = GW'(fine_n) * GW'(FINE_CDB)
                 + GW'(coarse_n) * GW'(COARSE_CDB)
                 + ((step_i == STEP_MAX) ? GW'(LAST_CDB) : '0);
        base     = GW'(base_cdb(gsel_e'(sel_i)));
        gain_o   = base + GW'(TRIM_CDB) - offset;
    end

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
    import agc_lim_pkg::*;
#(
    parameter int ATK_HOLD = 3,
    parameter int REL_CYC  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        gain_sel_i,
    input  logic              bypass_i,
    input  logic              over_i,
    output logic [STEP_W-1:0] step_o,
    output logic [1:0]        sel_o
);
    localparam int ATK_W = (ATK_HOLD < 1) ? 1 : $clog2(ATK_HOLD + 1);
    localparam int REL_W = (REL_CYC < 2) ? 1 : $clog2(REL_CYC);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [ATK_W-1:0]  atk;
        logic [REL_W-1:0]  rel;
        logic [1:0]        sel;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sel = gain_sel_i;
        if (bypass_i) begin
            st_d.step = STEP_MIN;
            st_d.atk  = '0;
            st_d.rel  = '0;
        end else if (gain_sel_i != st_q.sel) begin
            st_d.step = STEP_MIN;
            st_d.atk  = '0;
            st_d.rel  = '0;
        end else if (over_i) begin
            st_d.rel = '0;
            if (st_q.atk == '0) begin
                if (st_q.step != STEP_MAX) st_d.step = st_q.step + 1'b1;
                st_d.atk = ATK_W'(ATK_HOLD);
            end else begin
                st_d.atk = st_q.atk - 1'b1;
            end
        end else begin
            if (st_q.atk != '0) st_d.atk = st_q.atk - 1'b1;
            if (st_q.rel == REL_W'(REL_CYC - 1)) begin
                st_d.rel = '0;
                if (st_q.step != STEP_MIN) st_d.step = st_q.step - 1'b1;
            end else begin
                st_d.rel = st_q.rel + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{step: STEP_MIN, atk: '0, rel: '0, sel: 2'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = st_q.step;
    assign sel_o  = st_q.sel;

    p_step_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.step >= STEP_MIN) && (st_q.step <= STEP_MAX));

    p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bypass_i |=> (st_q.step == STEP_MIN));

    p_selchg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gain_sel_i != st_q.sel) |=> (st_q.step == STEP_MIN));

    p_single_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.step == $past(st_q.step))
               || (st_q.step == $past(st_q.step) + 6'd1)
               || (st_q.step + 6'd1 == $past(st_q.step))
               || (st_q.step == STEP_MIN)));

    p_hold_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (over_i && !bypass_i && (gain_sel_i == st_q.sel) && (st_q.atk != '0))
        |=> $stable(st_q.step));

    p_release_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!over_i && !bypass_i && (gain_sel_i == st_q.sel)) |=>
        (st_q.step + 6'd1 >= $past(st_q.step)) && (st_q.step <= $past(st_q.step)));

    p_over_no_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (over_i && !bypass_i && (gain_sel_i == st_q.sel)) |=>
        (st_q.step >= $past(st_q.step)));

endmodule

// File: rtl/agc_gain_limiter.sv
module agc_gain_limiter
    import agc_lim_pkg::*;
#(
    parameter int LCW      = 8,
    parameter int PW       = 12,
    parameter int GW       = 10,
    parameter int KNEE     = 125,
    parameter int MUL      = 179,
    parameter int SHIFT    = 5,
    parameter int ATK_HOLD = 3,
    parameter int REL_CYC  = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [1:0]     gain_sel_i,
    input  logic [LCW-1:0] limit_code_i,
    input  logic           peak_valid_i,
    input  logic [PW-1:0]  peak_mag_i,
    input  logic           bypass_i,
    output logic [5:0]     step_o,
    output logic [GW-1:0]  gain_o
);
    logic              over;
    logic [STEP_W-1:0] step_q;
    logic [1:0]        sel_q;

    agc_limit_calc #(
        .LCW(LCW), .PW(PW), .KNEE(KNEE), .MUL(MUL), .SHIFT(SHIFT)
    ) u_limit (
        .limit_code_i (limit_code_i),
        .peak_valid_i (peak_valid_i),
        .peak_mag_i   (peak_mag_i),
        .over_o       (over)
    );

    agc_step_ctrl #(
        .ATK_HOLD(ATK_HOLD), .REL_CYC(REL_CYC)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .gain_sel_i (gain_sel_i),
        .bypass_i   (bypass_i),
        .over_i     (over),
        .step_o     (step_q),
        .sel_o      (sel_q)
    );

    agc_gain_map #(
        .GW(GW)
    ) u_map (
        .sel_i  (sel_q),
        .step_i (step_q),
        .gain_o (gain_o)
    );

    assign step_o = step_q;

    p_gain_falls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((step_q == $past(step_q) + 6'd1) && (sel_q == $past(sel_q)))
        |-> (gain_o < $past(gain_o)));

    p_deepest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_q == STEP_MAX) |-> (gain_o < GW'(TRIM_CDB + 321)));

endmodule

// File: tb/agc_gain_limiter_tb_top.sv
`timescale 1ns/1ps
module agc_gain_limiter_tb_top;

    localparam int ATK_HOLD = 3;
    localparam int REL_CYC  = 16;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  gain_sel_i = 2'd0;
    logic [7:0]  limit_code_i = 8'd0;
    logic        peak_valid_i = 1'b0;
    logic [11:0] peak_mag_i = 12'd0;
    logic        bypass_i = 1'b0;
    logic [5:0]  step_o;
    logic [9:0]  gain_o;

    agc_gain_limiter dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .gain_sel_i(gain_sel_i),
        .limit_code_i(limit_code_i), .peak_valid_i(peak_valid_i),
        .peak_mag_i(peak_mag_i), .bypass_i(bypass_i),
        .step_o(step_o), .gain_o(gain_o)
    );

    always #2 clk_i = ~clk_i;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    string tag = "R1";

    int m_step = 1, m_atk = 0, m_rel = 0, m_sel = 0;

    function automatic int ref_gain(int sel, int step);
        int g;
        int b [4] = '{400, 520, 640, 720};
        g = b[sel] + 3;
        for (int k = 2; k <= step; k++)
            g -= (k <= 25) ? 10 : ((k <= 31) ? 20 : 40);
        return g;
    endfunction

    function automatic bit ref_over(int code, bit vld, int pk);
        int c;
        c = (code > 125) ? 125 : code;
        return vld && (pk > (c * 179) / 32);
    endfunction

    task automatic model_edge();
        bit ov;
        ov = ref_over(limit_code_i, peak_valid_i, peak_mag_i);
        if (bypass_i || int'(gain_sel_i) != m_sel) begin
            m_step = 1; m_atk = 0; m_rel = 0;
        end else if (ov) begin
            m_rel = 0;
            if (m_atk == 0) begin
                if (m_step < 32) m_step++;
                m_atk = ATK_HOLD;
            end else m_atk--;
        end else begin
            if (m_atk > 0) m_atk--;
            if (m_rel == REL_CYC - 1) begin
                m_rel = 0;
                if (m_step > 1) m_step--;
            end else m_rel++;
        end
        m_sel = gain_sel_i;
    endtask

    task automatic compare();
        int eg;
        eg = ref_gain(m_sel, m_step);
        n_chk++;
        if (int'(step_o) != m_step || int'(gain_o) != eg) begin
            n_bad++;
            $display("FAIL %s: step=%0d exp %0d, gain=%0d exp %0d",
                     tag, step_o, m_step, gain_o, eg);
        end
    endtask

    task automatic check_val(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_i);
            model_edge();
            #1;
            compare();
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        int hold;
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        // R1: reset state
        check_val("R1", int'(step_o), 1);
        check_val("R1", int'(gain_o), 403);

        // R2: base gains at step 1
        tag = "R2";
        for (int s = 0; s < 4; s++) begin
            gain_sel_i = 2'(s);
            run(3);
            check_val("R2", int'(gain_o), ref_gain(s, 1));
        end
        gain_sel_i = 2'd0;
        run(2);

        // R4: limit boundary, code 50 -> 279; code 200 clamps -> 699
        tag = "R4";
        limit_code_i = 8'd50; peak_valid_i = 1'b1; peak_mag_i = 12'd279;
        run(10);
        check_val("R4", int'(step_o), 1);
        limit_code_i = 8'd200; peak_mag_i = 12'd699;
        run(4);
        check_val("R4", int'(step_o), 1);
        peak_mag_i = 12'd700;
        run(1);
        check_val("R4", int'(step_o), 2);

        // R3 / R5 / R6: climb to the deepest step and saturate
        tag = "R3/R5";
        peak_mag_i = 12'd2000;
        run(3);
        check_val("R5", int'(step_o), 2);
        run(1);
        check_val("R5", int'(step_o), 3);
        tag = "R6";
        run(4 * 32 + 10);
        check_val("R6", int'(step_o), 32);
        check_val("R3", int'(gain_o), 3);

        // R7: release back to step 1
        tag = "R7";
        peak_mag_i = 12'd0;
        run(REL_CYC * 33 + 5);
        check_val("R7", int'(step_o), 1);

        // R11: invalid samples do not count as overshoot
        tag = "R11";
        peak_mag_i = 12'd4095;
        run(9);
        hold = step_o;
        peak_valid_i = 1'b0;
        run(REL_CYC - 1);
        check_val("R11", int'(step_o), hold);
        run(REL_CYC + 2);

        // R8: bypass forces step 1, overshoot ignored
        tag = "R8";
        peak_valid_i = 1'b1;
        run(12);
        bypass_i = 1'b1;
        run(20);
        check_val("R8", int'(step_o), 1);
        bypass_i = 1'b0;
        run(6);

        // R9: select change in the same cycle as an overshoot
        tag = "R9";
        run(8);
        gain_sel_i = 2'd3;
        run(1);
        check_val("R9", int'(step_o), 1);
        check_val("R9", int'(gain_o), 723);
        run(10);

        // R10: random mix, sparse overshoots land on release expiry
        tag = "R10";
        limit_code_i = 8'd60;
        for (int i = 0; i < 2500; i++) begin
            int r;
            r = $urandom_range(0, 99);
            peak_valid_i = ($urandom_range(0, 3) != 0);
            peak_mag_i   = (r < 12) ? 12'd900 : 12'($urandom_range(0, 330));
            bypass_i     = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 299) == 0) gain_sel_i = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 399) == 0) limit_code_i = 8'($urandom_range(0, 255));
            run(1);
        end
        finish_up();
    end

endmodule